// File: doc/BRIEF.md
# SIMD High-Half Narrowing Add/Subtract Unit

This unit is one datapath slice of a 128-bit vector execution pipe. Each cycle it can accept one instruction word together with two 128-bit source vectors and the current value of the destination register. It treats the sources as lanes of double width, adds or subtracts them lane by lane with wrap-around, optionally adds half of one narrow LSB to round, and keeps only the upper half of every wide result. The narrow results are packed into either the low or the high 64 bits of the destination.

The unit decodes the instruction word itself. A word that does not belong to this instruction group, or that uses the reserved element size, is flagged as illegal and the destination value passes through unchanged. The result, the illegal flag and a valid strobe appear one clock after the request. Register-file access, hazard handling and trap generation belong to the surrounding pipeline.

Top module: `hn_narrow_unit`

## Requirements
- R1: A word is accepted only if bit 31 = 0, bits 28:24 = 01110, bit 21 = 1, bits 15:14 = 01 and bits 12:10 = 000. Any other word sets the illegal flag and returns the old destination unchanged. Bits 20:16 and 9:0 are register numbers and do not affect the result.
- R2: Element size code 3 (bits 23:22 = 11) is reserved. It sets the illegal flag and returns the old destination unchanged.
- R3: With bit 13 = 0 and bit 29 = 0, each result lane is the upper half of (a + b) taken modulo 2^(2N).
- R4: With bit 13 = 1, the wide value is a − b modulo 2^(2N), in two's complement. Bit 29 selects rounding for both the add form and the subtract form.
- R5: With bit 29 = 1, 2^(N−1) is added to the wrapped wide value before the upper half is taken. A carry out of the wide width is dropped.
- R6: Size code s (bits 23:22) gives narrow lanes of N = 8 << s bits. Each source supplies 8 >> s wide lanes of 2N bits, and lane i of a source is bits [2N·i +: 2N].
- R7: With bit 30 = 0, narrow lane i is written to dst bits [N·i +: N] and dst bits 127:64 are zero.
- R8: With bit 30 = 1, narrow lane i is written to dst bits [64 + N·i +: N] and dst bits 63:0 keep the old destination value.
- R9: out_valid_o is high in exactly the cycle after each cycle in which in_valid_i is high. Reset clears out_valid_o, dst_o and illegal_o, and dst_o and illegal_o hold their values while no request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request strobe |
| instr_i | input | 32 | Instruction word |
| src_a_i | input | 128 | First source vector |
| src_b_i | input | 128 | Second source vector |
| dst_old_i | input | 128 | Current destination value |
| out_valid_o | output | 1 | Result strobe, one cycle after the request |
| dst_o | output | 128 | New destination value |
| illegal_o | output | 1 | Request was not a legal encoding |

## Verification
The bench drives both all-ones and zero operands into every size. A design that loses the borrow out of 0 − all-ones, or that lets a rounding carry leak past the wide width, then returns a nonzero or wrong high half. A hand-computed vector with 0x0080 byte-pairs and rounding catches a missing or misplaced rounding constant. Both half-placement modes run with a random old destination, so a design that fails to zero the upper half, overwrites the preserved low half, or puts lanes in the wrong order is caught. Reserved size and malformed words are checked to pass the old destination through, and idle cycles are checked to hold the outputs.

// File: rtl/hn_pkg.sv
package hn_pkg;
  localparam int VEC_W     = 128;
  localparam int HALF_W    = VEC_W / 2;
  localparam int NUM_SIZES = 3;   // size codes 0..2 are legal
  localparam int INSTR_W   = 32;

  typedef struct packed {
    logic       hi_half;  // write upper half, keep lower
    logic       rnd;
    logic       sub;
    logic [1:0] size;
  } hn_dec_t;
endpackage

// File: rtl/hn_decode.sv
module hn_decode
  import hn_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output hn_dec_t            dec_o,
  output logic               illegal_o
);
  logic match;
  logic unused_regs;

  assign match = (instr_i[31] == 1'b0) && (instr_i[28:24] == 5'b01110) &&
                 instr_i[21] && (instr_i[15:14] == 2'b01) &&
                 (instr_i[12:10] == 3'b000);

  assign dec_o.hi_half = instr_i[30];
  assign dec_o.rnd     = instr_i[29];
  assign dec_o.sub     = instr_i[13];
  assign dec_o.size    = instr_i[23:22];

  assign illegal_o   = !match || (instr_i[23:22] == 2'b11);
  assign unused_regs = ^{instr_i[20:16], instr_i[9:0]};
endmodule

// File: rtl/hn_lane.sv
module hn_lane #(
  parameter int NARROW_W = 8
) (
  input  logic [2*NARROW_W-1:0] a_i,
  input  logic [2*NARROW_W-1:0] b_i,
  input  logic                  sub_i,
  input  logic                  rnd_i,
  output logic [NARROW_W-1:0]   res_o
);
  localparam int WIDE_W = 2 * NARROW_W;
  localparam logic [WIDE_W:0] RND_K = {{WIDE_W{1'b0}}, 1'b1} << (NARROW_W - 1);

  logic [WIDE_W-1:0] wide;
  logic [WIDE_W:0]   ext;
  logic              unused_carry;

  always_comb begin
    wide = sub_i ? (a_i - b_i) : (a_i + b_i);
    ext  = {1'b0, wide} + (rnd_i ? RND_K : '0);
  end

  assign res_o        = ext[WIDE_W-1:NARROW_W];
  assign unused_carry = ext[WIDE_W];
endmodule

// File: rtl/hn_narrow_array.sv
module hn_narrow_array #(
  parameter int VEC_W    = 128,
  parameter int NARROW_W = 8
) (
  input  logic [VEC_W-1:0]   a_i,
  input  logic [VEC_W-1:0]   b_i,
  input  logic               sub_i,
  input  logic               rnd_i,
  output logic [VEC_W/2-1:0] res_o
);
  localparam int WIDE_W = 2 * NARROW_W;
  localparam int LANES  = VEC_W / WIDE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    hn_lane #(.NARROW_W(NARROW_W)) lane_i (
      .a_i  (a_i[i*WIDE_W +: WIDE_W]),
      .b_i  (b_i[i*WIDE_W +: WIDE_W]),
      .sub_i(sub_i),
      .rnd_i(rnd_i),
      .res_o(res_o[i*NARROW_W +: NARROW_W])
    );
  end
endmodule

// File: rtl/hn_narrow_unit.sv
module hn_narrow_unit
  import hn_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               in_valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [VEC_W-1:0]   src_a_i,
  input  logic [VEC_W-1:0]   src_b_i,
  input  logic [VEC_W-1:0]   dst_old_i,
  output logic               out_valid_o,
  output logic [VEC_W-1:0]   dst_o,
  output logic               illegal_o
);
  hn_dec_t           dec;
  logic              illegal_d;
  logic [HALF_W-1:0] narrow_by_size [NUM_SIZES];
  logic [HALF_W-1:0] narrow_sel;
  logic [VEC_W-1:0]  dst_d;
  logic              out_valid_q, illegal_q;
  logic [VEC_W-1:0]  dst_q;

  hn_decode dec_i (
    .instr_i  (instr_i),
    .dec_o    (dec),
    .illegal_o(illegal_d)
  );

  // one lane array per legal element size
  for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
    hn_narrow_array #(.VEC_W(VEC_W), .NARROW_W(8 << s)) arr_i (
      .a_i  (src_a_i),
      .b_i  (src_b_i),
      .sub_i(dec.sub),
      .rnd_i(dec.rnd),
      .res_o(narrow_by_size[s])
    );
  end

  always_comb begin
    case (dec.size)
      2'd0:    narrow_sel = narrow_by_size[0];
      2'd1:    narrow_sel = narrow_by_size[1];
      2'd2:    narrow_sel = narrow_by_size[2];
      default: narrow_sel = '0;
    endcase
  end

  always_comb begin
    if (illegal_d)        dst_d = dst_old_i;
    else if (dec.hi_half) dst_d = {narrow_sel, dst_old_i[HALF_W-1:0]};
    else                  dst_d = {{HALF_W{1'b0}}, narrow_sel};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_q <= 1'b0;
      dst_q       <= '0;
      illegal_q   <= 1'b0;
    end else begin
      out_valid_q <= in_valid_i;
      if (in_valid_i) begin
        dst_q     <= dst_d;
        illegal_q <= illegal_d;
      end
    end
  end

  assign out_valid_o = out_valid_q;
  assign dst_o       = dst_q;
  assign illegal_o   = illegal_q;

  assert_valid_follows_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> (!out_valid_o && $stable(dst_o) && $stable(illegal_o)));
  assert_illegal_passthru_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && illegal_d) |=> (illegal_o && dst_o == $past(dst_old_i)));
  assert_lo_zero_upper_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !illegal_d && !instr_i[30]) |=> (dst_o[VEC_W-1:HALF_W] == '0));
  assert_hi_keep_lower_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !illegal_d && instr_i[30]) |=>
      (dst_o[HALF_W-1:0] == $past(dst_old_i[HALF_W-1:0])));
  assert_legal_flag_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !illegal_d) |=> !illegal_o);
endmodule

// File: tb/hn_narrow_unit_tb.sv
`timescale 1ns/1ps
module hn_narrow_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [31:0]  instr;
  logic [127:0] src_a, src_b, dst_old;
  logic         out_valid, illegal;
  logic [127:0] dst;
  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  hn_narrow_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .instr_i(instr),
    .src_a_i(src_a), .src_b_i(src_b), .dst_old_i(dst_old),
    .out_valid_o(out_valid), .dst_o(dst), .illegal_o(illegal)
  );

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  function automatic logic [31:0] mk(input logic q, input logic u, input logic sub,
                                     input logic [1:0] sz);
    return {1'b0, q, u, 5'b01110, sz, 1'b1, 5'd7, 2'b01, sub, 3'b000, 5'd3, 5'd9};
  endfunction

  function automatic logic ref_ill(input logic [31:0] w);
    logic ok;
    ok = !w[31] && (w[28:24] == 5'b01110) && w[21] && (w[15:14] == 2'b01) &&
         (w[12:10] == 3'b000) && (w[23:22] != 2'b11);
    return !ok;
  endfunction

  function automatic logic [127:0] ref_dst(input logic [31:0] w, input logic [127:0] a,
                                           input logic [127:0] b, input logic [127:0] old);
    int nw, lanes, base;
    logic [128:0] wm, nm, wa, wb, s;
    logic [127:0] r;
    if (ref_ill(w)) return old;
    nw    = 8 << w[23:22];
    lanes = 8 >> w[23:22];
    base  = w[30] ? 64 : 0;
    wm = (129'(1) << (2 * nw)) - 129'(1);
    nm = (129'(1) << nw) - 129'(1);
    r  = w[30] ? {64'b0, old[63:0]} : 128'b0;
    for (int i = 0; i < lanes; i++) begin
      wa = ({1'b0, a} >> (i * 2 * nw)) & wm;
      wb = ({1'b0, b} >> (i * 2 * nw)) & wm;
      s  = (w[13] ? (wa - wb) : (wa + wb)) & wm;
      if (w[29]) s = s + (129'(1) << (nw - 1));
      s  = (s >> nw) & nm;
      r  = r | (128'(s) << (base + i * nw));
    end
    return r;
  endfunction

  task automatic do_op(input logic [31:0] w, input logic [127:0] a, input logic [127:0] b,
                       input logic [127:0] old, input string tag);
    @(negedge clk);
    instr = w; src_a = a; src_b = b; dst_old = old; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R9 valid"}, {127'b0, out_valid}, 128'd1);
    chk({tag, " R1 illegal"}, {127'b0, illegal}, {127'b0, ref_ill(w)});
    chk({tag, " dst"}, dst, ref_dst(w, a, b, old));
  endtask

  task automatic test_reset();
    chk("R9 reset valid", {127'b0, out_valid}, 128'd0);
    chk("R9 reset dst", dst, 128'd0);
    chk("R9 reset illegal", {127'b0, illegal}, 128'd0);
  endtask

  task automatic test_plain_add();
    for (int sz = 0; sz < 3; sz++)
      for (int q = 0; q < 2; q++)
        do_op(mk(q[0], 1'b0, 1'b0, sz[1:0]), rnd128(), rnd128(), rnd128(), "R3 R6 R7 R8 add");
  endtask

  task automatic test_sub();
    for (int sz = 0; sz < 3; sz++)
      for (int q = 0; q < 2; q++)
        do_op(mk(q[0], 1'b0, 1'b1, sz[1:0]), rnd128(), rnd128(), rnd128(), "R4 sub");
  endtask

  task automatic test_round();
    // hand value: byte pairs 0x0080 + 0, rounded -> 0x01 in every byte
    do_op(mk(1'b0, 1'b1, 1'b0, 2'd0), {8{16'h0080}}, 128'd0, rnd128(), "R5 hand");
    chk("R5 hand literal", dst, {64'd0, 64'h0101010101010101});
    for (int sz = 0; sz < 3; sz++)
      for (int op = 0; op < 2; op++)
        do_op(mk(sz[0], 1'b1, op[0], sz[1:0]), rnd128(), rnd128(), rnd128(), "R5 R4 round");
  endtask

  task automatic test_extremes();
    logic [127:0] ones = '1;
    for (int sz = 0; sz < 3; sz++) begin
      do_op(mk(1'b0, 1'b0, 1'b0, sz[1:0]), ones, ones, rnd128(), "R3 carry");
      do_op(mk(1'b1, 1'b0, 1'b1, sz[1:0]), 128'd0, ones, rnd128(), "R4 borrow");
      do_op(mk(1'b0, 1'b1, 1'b0, sz[1:0]), ones, 128'd0, rnd128(), "R5 round wrap");
      do_op(mk(1'b1, 1'b1, 1'b1, sz[1:0]), ones, 128'd0, ones, "R5 R8 round sub");
    end
    // all-ones minus zero, 32-bit narrow, low half
    do_op(mk(1'b0, 1'b0, 1'b1, 2'd2), ones, 128'd0, ones, "R4 R7 literal");
    chk("R7 literal", dst, {64'd0, 64'hFFFFFFFF_FFFFFFFF});
  endtask

  task automatic test_illegal();
    logic [127:0] old;
    for (int q = 0; q < 2; q++) begin
      old = rnd128();
      do_op(mk(q[0], 1'b1, 1'b0, 2'd3), rnd128(), rnd128(), old, "R2 size3");
      chk("R2 size3 keep", dst, old);
    end
    old = rnd128();
    do_op(mk(1'b0, 1'b0, 1'b0, 2'd1) & ~32'h0020_0000, rnd128(), rnd128(), old, "R1 bit21");
    chk("R1 bit21 keep", dst, old);
    do_op(mk(1'b1, 1'b0, 1'b0, 2'd0) | 32'h0000_1000, rnd128(), rnd128(), old, "R1 bit12");
    do_op(mk(1'b0, 1'b0, 1'b0, 2'd0) | 32'h8000_0000, rnd128(), rnd128(), old, "R1 bit31");
    // register fields must not matter
    do_op(mk(1'b0, 1'b0, 1'b1, 2'd1) ^ 32'h001F_03FF, rnd128(), rnd128(), rnd128(), "R1 regs");
  endtask

  task automatic test_idle();
    logic [127:0] held;
    do_op(mk(1'b1, 1'b0, 1'b0, 2'd1), rnd128(), rnd128(), rnd128(), "R9 pre-idle");
    held = dst;
    @(negedge clk);
    src_a = rnd128(); src_b = rnd128(); dst_old = rnd128(); instr = mk(1'b0, 1'b1, 1'b1, 2'd0);
    @(negedge clk);
    chk("R9 idle valid", {127'b0, out_valid}, 128'd0);
    chk("R9 idle hold", dst, held);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog R9 act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; instr = '0;
    src_a = '0; src_b = '0; dst_old = '0;
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    test_plain_add();
    test_sub();
    test_round();
    test_extremes();
    test_illegal();
    test_idle();
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule